// File: doc/BRIEF.md
# Strap-Configured Host Bus Slave

This block is a synchronous slave that connects a 16-bit host processor bus to a small internal register file. Five shared pins are sampled as configuration straps while reset is held. When reset is released their last sampled values are frozen, and the pins are passed on as five bits of an internal data path.

The straps fix four things about the bus. They set whether every clock or every second clock is a bus phase, whether bytes are swapped between the bus and the registers, which level of the read/write line means a read, and whether ready comes with the read data or one phase ahead of it. One strap nominally selects bus width; in this 16-bit-only variant it has no effect.

An access starts when address strobe and chip select are both low. Ready and the 16-bit size response are presented as pull-low enables, as for open-drain pins. Word 0 of the register file is a control word whose bit 0 sets the active level of the single interrupt output.

Top module: `hbs_cpu_slave`

## Requirements
- R1: While rst_n is low the strap register takes strap_pins on every clock, so the value present at the last clock before release is kept until the next reset, and later pin changes do not alter bus behaviour. fwd_data is 0 during reset and equals strap_pins after it.
- R2: With strap bit 0 low, every clock is a bus phase. With it high, only every second clock is a bus phase, and each phase lasts two clocks. An access lasts two phases: an address phase and then a data phase.
- R3: With strap bit 1 high (big-endian), bits 15:8 and 7:0 are exchanged between the bus and the stored word in both directions. With it low, words pass unchanged.
- R4: With strap bit 2 low, bus_rwc=1 means read and 0 means write. With it high, bus_rwc=1 means write and 0 means read.
- R5: Strap bit 3 has no effect, and all 16 data bits are always transferred.
- R6: With strap bit 4 high, rdy_pull is 1 in exactly the data-phase clocks, together with read data. With it low, rdy_pull is 1 in exactly the address-phase clocks and never together with bus_doe.
- R7: An access starts only in a bus phase in which bus_ads_n and bus_cs_n are both 0. bs16_pull is 1 in every clock of a selected access and 0 otherwise.
- R8: bus_doe is 1 only in the data phase of a read. bus_dout then carries the word that was stored when the address was captured.
- R9: A write stores bus_din, byte-ordered per R3, at the word selected by bus_addr[11:1], in the clock in which rdy_pull is given.
- R10: Control word 0 bit 0 (reset value 0) sets interrupt polarity: 0 gives irq_out = !evt_in and 1 gives irq_out = evt_in. A read of word 0 returns that bit in bit 0 and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| strap_pins | input | 5 | Straps during reset, data bits afterwards |
| fwd_data | output | 5 | Pins forwarded to the internal data path after reset |
| bus_addr | input | 11 | Word address, bits 11:1 |
| bus_ads_n | input | 1 | Address strobe, active low |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rwc | input | 1 | Read/write control, meaning set by strap bit 2 |
| bus_din | input | 16 | Write data from the host |
| bus_dout | output | 16 | Read data to the host |
| bus_doe | output | 1 | Data output enable |
| rdy_pull | output | 1 | 1 = pull ready pin low (ready asserted) |
| bs16_pull | output | 1 | 1 = pull bus-size-16 pin low |
| evt_in | input | 1 | Internal interrupt event |
| irq_out | output | 1 | Interrupt to the host |

## Verification
A strap latched wrongly shows up at the ports on the first access after reset: the clocks counted under bs16_pull, rdy_pull and bus_doe, or a byte-swapped or missing data phase, differ from what the mode requires. A bus state machine stuck in a phase keeps bs16_pull asserted, and a read snapshot taken at the wrong time returns a different stored word, within the same access. A wrong polarity bit is visible on irq_out in the very clock after the control write.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
  localparam int DATA_W  = 16;
  localparam int STRAP_W = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} bus_st_e;

  // packed from strap pins 4,2,1,0 (pin 3 carries no function)
  typedef struct packed {
    logic rdy_aligned;
    logic w_high;
    logic big_end;
    logic dbl_clk;
  } strap_t;

  function automatic logic [DATA_W-1:0] bswap(input logic [DATA_W-1:0] v, input logic en);
    return en ? {v[DATA_W/2-1:0], v[DATA_W-1:DATA_W/2]} : v;
  endfunction
endpackage

// File: rtl/hbs_strap_cap.sv
module hbs_strap_cap
  import hbs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] pins,
  output strap_t             straps,
  output logic [STRAP_W-1:0] fwd
);
  strap_t cap_q;
  strap_t cap_d;

  always_comb begin
    cap_d = cap_q;
    if (!rst_n) cap_d = strap_t'({pins[4], pins[2:0]});
  end

  always_ff @(posedge clk) begin
    cap_q <= cap_d;
  end

  assign straps = cap_q;
  assign fwd    = rst_n ? pins : '0;

  p_strap_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(cap_q));
endmodule

// File: rtl/hbs_phase_gen.sv
module hbs_phase_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic dbl,
  output logic ce
);
  logic phase_q;
  logic phase_d;

  always_comb phase_d = ~phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end

  assign ce = dbl ? phase_q : 1'b1;

  p_half_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl && ce) |=> !ce);
endmodule

// File: rtl/hbs_bus_fsm.sv
module hbs_bus_fsm
  import hbs_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              early,
  input  logic              w_high,
  input  logic              big_end,
  input  logic              ads_n,
  input  logic              cs_n,
  input  logic              rwc,
  input  logic [ADDR_W:1]   addr,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W:1]   wr_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] dout,
  output logic              doe,
  output logic              rdy_oe,
  output logic              bs_oe
);
  bus_st_e           st_q, st_d;
  logic [ADDR_W:1]   addr_q, addr_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              isrd_q, isrd_d;
  logic              start;
  logic              rdy_phase;

  assign start = ce && (st_q == ST_IDLE) && !ads_n && !cs_n;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    rd_d   = rd_q;
    isrd_d = isrd_q;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d   = ST_ADDR;
        addr_d = addr;
        rd_d   = rd_word;
        isrd_d = w_high ? !rwc : rwc;
      end
      ST_ADDR: if (ce) st_d = ST_DATA;
      ST_DATA: if (ce) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      rd_q   <= '0;
      isrd_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      rd_q   <= rd_d;
      isrd_q <= isrd_d;
    end
  end

  assign rdy_phase = early ? (st_q == ST_ADDR) : (st_q == ST_DATA);
  assign rdy_oe    = rdy_phase;
  assign bs_oe     = (st_q != ST_IDLE);
  assign doe       = (st_q == ST_DATA) && isrd_q;
  assign dout      = bswap(rd_q, big_end);
  assign wr_en     = ce && rdy_phase && !isrd_q;
  assign wr_addr   = addr_q;
  assign wr_data   = bswap(din, big_end);

  p_idle_needs_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bs_oe && (ads_n || cs_n)) |=> !bs_oe);
  p_early_ready_leads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (early && rdy_oe && ce && isrd_q) |=> doe);
  p_aligned_ready_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!early && rdy_oe && isrd_q) |-> doe);
  p_data_inside_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
    doe |-> bs_oe);
  p_single_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
endmodule

// File: rtl/hbs_regfile.sv
module hbs_regfile
  import hbs_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              evt,
  output logic              irq
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];
  logic              pol_q, pol_d;
  logic              ctl_hit;

  assign ctl_hit = wr_en && (wr_idx == '0);

  always_comb begin
    pol_d = pol_q;
    if (ctl_hit) pol_d = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pol_q <= 1'b0;
    else        pol_q <= pol_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !ctl_hit) mem[wr_idx] <= wr_data;
  end

  assign rd_data = (rd_idx == '0) ? {{(DATA_W-1){1'b0}}, pol_q} : mem[rd_idx];
  assign irq     = pol_q ? evt : !evt;

  p_polarity_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_hit |=> (irq == (evt ~^ $past(wr_data[0]))) || $changed(evt));
endmodule

// File: rtl/hbs_cpu_slave.sv
module hbs_cpu_slave
  import hbs_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_pins,
  output logic [STRAP_W-1:0] fwd_data,
  input  logic [ADDR_W:1]    bus_addr,
  input  logic               bus_ads_n,
  input  logic               bus_cs_n,
  input  logic               bus_rwc,
  input  logic [DATA_W-1:0]  bus_din,
  output logic [DATA_W-1:0]  bus_dout,
  output logic               bus_doe,
  output logic               rdy_pull,
  output logic               bs16_pull,
  input  logic               evt_in,
  output logic               irq_out
);
  strap_t            straps;
  logic              ce;
  logic [ADDR_W:1]   wr_addr;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_word;

  hbs_strap_cap u_strap (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins   (strap_pins),
    .straps (straps),
    .fwd    (fwd_data)
  );

  hbs_phase_gen u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .dbl   (straps.dbl_clk),
    .ce    (ce)
  );

  hbs_bus_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce      (ce),
    .early   (!straps.rdy_aligned),
    .w_high  (straps.w_high),
    .big_end (straps.big_end),
    .ads_n   (bus_ads_n),
    .cs_n    (bus_cs_n),
    .rwc     (bus_rwc),
    .addr    (bus_addr),
    .din     (bus_din),
    .rd_word (rd_word),
    .wr_addr (wr_addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .dout    (bus_dout),
    .doe     (bus_doe),
    .rdy_oe  (rdy_pull),
    .bs_oe   (bs16_pull)
  );

  hbs_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (bus_addr),
    .rd_data (rd_word),
    .wr_en   (wr_en),
    .wr_idx  (wr_addr),
    .wr_data (wr_data),
    .evt     (evt_in),
    .irq     (irq_out)
  );
endmodule

// File: tb/hbs_cpu_slave_tb.sv
module hbs_cpu_slave_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  strap_pins;
  logic [4:0]  fwd_data;
  logic [11:1] bus_addr;
  logic        bus_ads_n, bus_cs_n, bus_rwc;
  logic [15:0] bus_din, bus_dout;
  logic        bus_doe, rdy_pull, bs16_pull, evt_in, irq_out;

  int n_chk = 0, n_fail = 0;
  int n_bs, n_rdy, n_oe, n_both;
  logic [15:0] exp_q [$];
  logic prev_oe = 1'b0;
  bit m_2x, m_be, m_wpol, m_al;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbs_cpu_slave u_dut (
    .clk(clk), .rst_n(rst_n), .strap_pins(strap_pins), .fwd_data(fwd_data),
    .bus_addr(bus_addr), .bus_ads_n(bus_ads_n), .bus_cs_n(bus_cs_n), .bus_rwc(bus_rwc),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe), .rdy_pull(rdy_pull),
    .bs16_pull(bs16_pull), .evt_in(evt_in), .irq_out(irq_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: counts port activity and scores read data
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (bs16_pull) n_bs++;
      if (rdy_pull) n_rdy++;
      if (bus_doe) n_oe++;
      if (rdy_pull && bus_doe) n_both++;
      if (bus_doe && !prev_oe) begin
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected data phase", bus_dout, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(bus_dout === e, "R8 read data", bus_dout, e);
        end
      end
    end
    prev_oe = bus_doe;
  end

  task automatic do_reset(input logic [4:0] s);
    @(negedge clk); #1;
    rst_n = 1'b0; strap_pins = ~s;
    bus_ads_n = 1'b1; bus_cs_n = 1'b1;
    repeat (2) @(posedge clk);
    #1 strap_pins = s;
    chk(fwd_data == 5'd0, "R1 fwd zero in reset", fwd_data, 0);
    chk(!bs16_pull && !rdy_pull && !bus_doe, "R7 idle in reset",
        {bs16_pull, rdy_pull, bus_doe}, 0);
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    rst_n = 1'b1;
    m_2x = s[0]; m_be = s[1]; m_wpol = s[2]; m_al = s[4];
    strap_pins = ~s;
    #1 chk(fwd_data == ~s, "R1 fwd follows pins", fwd_data, ~s);
  endtask

  task automatic bus_cycle(input int idx, input bit is_rd, input logic [15:0] wd,
                           input logic [15:0] ex);
    int ph;
    ph = m_2x ? 2 : 1;
    @(negedge clk); #1;
    n_bs = 0; n_rdy = 0; n_oe = 0; n_both = 0;
    if (is_rd) exp_q.push_back(ex);
    bus_addr = idx[10:0];
    bus_rwc = m_wpol ? !is_rd : is_rd;
    bus_din = wd;
    bus_ads_n = 1'b0; bus_cs_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1;
      if (bs16_pull) break;
    end
    bus_ads_n = 1'b1; bus_cs_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1;
      if (!bs16_pull) break;
    end
    chk(n_bs == 2*ph, "R2 R7 bs16 clocks", n_bs, 2*ph);
    chk(n_rdy == ph, "R6 ready clocks", n_rdy, ph);
    chk(n_oe == (is_rd ? ph : 0), "R4/R8 data enable clocks", n_oe, is_rd ? ph : 0);
    chk(n_both == ((is_rd && m_al) ? ph : 0), "R6 ready with data", n_both,
        (is_rd && m_al) ? ph : 0);
  endtask

  task automatic unselected(input bit ads, input bit cs);
    @(negedge clk); #1;
    n_bs = 0; n_oe = 0;
    bus_addr = 11'd3; bus_rwc = m_wpol; bus_din = 16'hDEAD;
    bus_ads_n = ads; bus_cs_n = cs;
    repeat (5) @(negedge clk);
    #1 bus_ads_n = 1'b1; bus_cs_n = 1'b1;
    chk(n_bs == 0 && n_oe == 0, "R7 no cycle without both strobes", n_bs, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; strap_pins = 5'd0; bus_addr = '0; bus_ads_n = 1'b1;
    bus_cs_n = 1'b1; bus_rwc = 1'b1; bus_din = '0; evt_in = 1'b0;

    // 1X, little-endian, rwc high = read, aligned ready
    do_reset(5'b10000);
    chk(irq_out == 1'b1, "R10 reset polarity", irq_out, 1);
    chk(!bs16_pull && !rdy_pull && !bus_doe, "R7 idle after reset", bs16_pull, 0);
    bus_cycle(3, 0, 16'h1234, 0);
    bus_cycle(5, 0, 16'hBEEF, 0);
    bus_cycle(3, 1, 0, 16'h1234);   // R9
    bus_cycle(5, 1, 0, 16'hBEEF);
    unselected(1'b0, 1'b1);
    unselected(1'b1, 1'b0);
    bus_cycle(3, 1, 0, 16'h1234);   // R7 write ignored

    // interrupt polarity
    evt_in = 1'b1; #1;
    chk(irq_out == 1'b0, "R10 active-low event", irq_out, 0);
    bus_cycle(0, 0, 16'h0001, 0);
    bus_cycle(0, 1, 0, 16'h0001);
    chk(irq_out == 1'b1, "R10 active-high event", irq_out, 1);
    evt_in = 1'b0; #1;
    chk(irq_out == 1'b0, "R10 active-high idle", irq_out, 0);

    // 1X early ready; the strap pins change after reset (R1)
    do_reset(5'b00000);
    chk(irq_out == 1'b1, "R10 polarity reset again", irq_out, 1);
    bus_cycle(3, 1, 0, 16'h1234);
    bus_cycle(7, 0, 16'h0F0F, 0);
    bus_cycle(7, 1, 0, 16'h0F0F);

    // 2X, big-endian, early
    do_reset(5'b00011);
    bus_cycle(3, 1, 0, 16'h3412);   // R3
    bus_cycle(0, 1, 0, 16'h0000);
    bus_cycle(8, 0, 16'hA1B2, 0);
    bus_cycle(8, 1, 0, 16'hA1B2);

    // 2X, little-endian, rwc high = write, aligned
    do_reset(5'b10101);
    bus_cycle(8, 1, 0, 16'hB2A1);   // R3 stored swapped
    bus_cycle(9, 0, 16'h1357, 0);   // R4
    bus_cycle(9, 1, 0, 16'h1357);

    // width strap set: ignored (R5)
    do_reset(5'b11000);
    bus_cycle(9, 1, 0, 16'h1357);
    bus_cycle(5, 1, 0, 16'hBEEF);
    bus_cycle(10, 0, 16'hFF00, 0);
    bus_cycle(10, 1, 0, 16'hFF00);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all reads returned data", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule